// File: doc/BRIEF.md
# Prescaled Tick Strobe Generator

This block derives eight time-base strobes from the main clock without creating any new clock net. A free-running binary counter advances once per main-clock cycle. Each strobe is a one-cycle pulse taken from the rising transition of one counter bit. The counter bits are chosen so that the eight strobes repeat every 2, 4, 8, 64, 128, 1024, 2048 and 4096 cycles. A peripheral that needs a slow time base uses its own 3-bit select code to pick one strobe, and runs its logic only on cycles where that strobe is high.

Each peripheral drives one request bit while it needs a time base. When every request bit is low, the generator parks. The counter and the edge-detect state are held at zero, so no node toggles and every strobe stays low. After requests return, each strobe restarts from the beginning of its period. A select helper returns the strobe for a given code, so a single peripheral or a test can observe any tap through one pin.

Top module: `tick_gen`

## Requirements
- R1: While rst_ni is low, every bit of tick_o and tick_sel_o is 0.
- R2: At most one bit of tick_o is high in any cycle, and no bit of tick_o is high in two consecutive cycles.
- R3: Bit c of tick_o, for c = 0 to 7, has a period of 2, 4, 8, 64, 128, 1024, 2048 and 4096 main-clock cycles respectively. The select code c (sel_i = 0 to 7) chooses bit c.
- R4: Number the rising edges of a run of consecutive edges with req_i nonzero from 0, starting at the first edge after an idle or reset. The tap with period D is high after edge k exactly when k mod D equals D/2. Under this rule no strobe follows edge 0, and the first strobe of each tap follows edge D/2.
- R5: A rising edge at which every bit of req_i is 0 forces tick_o to 0 after that edge. The counter is cleared as well, so the timing of R4 restarts at the next active edge.
- R6: tick_sel_o equals bit sel_i of tick_o in the same cycle.
- R7: The generator runs while any one request bit is high. Which bit is high has no effect: passing the request from one bit to another without a cycle in which all bits are low keeps the phase of every strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_REQ | Per-peripheral time-base request, any bit high keeps the generator running |
| sel_i | input | 3 | Select code for tick_sel_o |
| tick_o | output | 8 | One-cycle strobes, bit c repeats every 2, 4, 8, 64, 128, 1024, 2048, 4096 cycles |
| tick_sel_o | output | 1 | The strobe picked by sel_i |

## Verification
Two functions can fall in the same cycle. The first is the emission of a due strobe. The second is the power-down caused by every request bit falling.

The bench provokes this collision on purpose. It watches its own edge count and drops all requests exactly before the edge that would raise the period-128 tap. It then expects that tap to stay low and expects the next run to restart from edge 0. The behavioural model predicts every cycle from a run counter and the modulo rule of R4. Any late clear or leftover edge-detect state therefore shows up as a mismatch on the first cycles after idle and after reactivation.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int NUM_TAPS = 8;
  localparam int SEL_W    = $clog2(NUM_TAPS);
  localparam int CNT_W    = 12;

  // counter bit whose rising transition forms tap i (period 2^(bit+1))
  function automatic int tap_bit(input int i);
    case (i)
      0: tap_bit = 0;
      1: tap_bit = 1;
      2: tap_bit = 2;
      3: tap_bit = 5;
      4: tap_bit = 6;
      5: tap_bit = 9;
      6: tap_bit = 10;
      default: tap_bit = 11;
    endcase
  endfunction
endpackage

// File: rtl/tick_activity.sv
module tick_activity #(
  parameter int NUM_REQ = 4
) (
  input  logic [NUM_REQ-1:0] req_i,
  output logic               run_o
);
  assign run_o = |req_i;
endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import tick_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  output logic [NUM_TAPS-1:0] tap_cur_o,
  output logic [NUM_TAPS-1:0] tap_prev_o
);
  logic [W-1:0]        cnt_q;
  logic [NUM_TAPS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int B = tap_bit(i);
    assign tap_cur_o[i] = cnt_q[B];
    // only tap bits keep a delayed copy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     prev_q[i] <= 1'b0;
      else if (!run_i) prev_q[i] <= 1'b0;
      else             prev_q[i] <= cnt_q[B];
    end
  end

  assign tap_prev_o = prev_q;
endmodule

// File: rtl/tick_edge.sv
module tick_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic cur_i,
  input  logic prev_i,
  output logic tick_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_o <= 1'b0;
    else         tick_o <= run_i & cur_i & ~prev_i;
  end
endmodule

// File: rtl/tick_mux.sv
module tick_mux
  import tick_pkg::*;
(
  input  logic [NUM_TAPS-1:0] tick_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                tick_o
);
  assign tick_o = tick_i[sel_i];
endmodule

// File: rtl/tick_gen.sv
module tick_gen
  import tick_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REQ-1:0]  req_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [NUM_TAPS-1:0] tick_o,
  output logic                tick_sel_o
);
  logic                run;
  logic [NUM_TAPS-1:0] tap_cur;
  logic [NUM_TAPS-1:0] tap_prev;

  tick_activity #(.NUM_REQ(NUM_REQ)) u_act (
    .req_i (req_i),
    .run_o (run)
  );

  tick_divider #(.W(CNT_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tap_cur_o  (tap_cur),
    .tap_prev_o (tap_prev)
  );

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_edge
    tick_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .cur_i  (tap_cur[i]),
      .prev_i (tap_prev[i]),
      .tick_o (tick_o[i])
    );
  end

  tick_mux u_mux (
    .tick_i (tick_o),
    .sel_i  (sel_i),
    .tick_o (tick_sel_o)
  );
endmodule

// File: rtl/tick_gen_chk.sv
module tick_gen_chk
  import tick_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_REQ-1:0]  req_i,
  input logic [SEL_W-1:0]    sel_i,
  input logic [NUM_TAPS-1:0] tick_o,
  input logic                tick_sel_o
);
  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tick_o));

  assert_one_wide_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tick_o) |=> ((tick_o & $past(tick_o)) == '0));

  assert_idle_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> (tick_o == '0));

  assert_tick_needs_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tick_o) |-> $past(|req_i));

  assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> ##1 ((tick_o & ~NUM_TAPS'(1)) == '0));

  assert_sel_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_sel_o |-> (|tick_o));

  // sel_i is only used through tick_sel_o
  logic unused_sel;
  assign unused_sel = ^sel_i;
endmodule

bind tick_gen tick_gen_chk #(.NUM_REQ(NUM_REQ)) u_chk (.*);

// File: tb/tick_gen_tb.sv
module tick_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [NREQ-1:0] req_i = '0;
  logic [2:0] sel_i = '0;
  logic [7:0] tick_o;
  logic       tick_sel_o;

  int checks = 0;
  int fails = 0;
  int run = 0;
  string tag = "R1";
  int div [8] = '{2, 4, 8, 64, 128, 1024, 2048, 4096};

  tick_gen #(.NUM_REQ(NREQ)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .sel_i(sel_i),
    .tick_o(tick_o), .tick_sel_o(tick_sel_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference: count of consecutive active edges
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run <= 0;
    else if (req_i != 0) run <= run + 1;
    else               run <= 0;
  end

  function automatic logic [7:0] exp_ticks(int r);
    logic [7:0] e = '0;
    if (r > 0)
      for (int c = 0; c < 8; c++) e[c] = (((r - 1) % div[c]) == div[c] / 2);
    return e;
  endfunction

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", t, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    logic [7:0] e;
    e = exp_ticks(run);
    chk(tag, 32'(tick_o), 32'(e));
    chk("R6", 32'(tick_sel_o), 32'(e[sel_i]));
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic measure(int code);
    int n;
    sel_i = 3'(code);
    @(negedge clk_i);
    while (!tick_sel_o) @(negedge clk_i);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!tick_sel_o && n < 5000);
    chk("R3", 32'(n), 32'(div[code]));
  endtask

  initial begin
    cycles(3);
    chk("R1", {23'b0, tick_sel_o, tick_o}, 32'h0);
    rst_ni = 1'b1;
    tag = "R5";
    cycles(20);
    tag = "R4";
    req_i = 4'b0001;
    cycles(9000);
    tag = "R3";
    for (int c = 0; c < 8; c++) measure(c);
    tag = "R7";
    req_i = 4'b1000;
    cycles(300);
    req_i = 4'b0100;
    cycles(300);
    // drop requests exactly before a period-128 strobe is due
    tag = "R5";
    while ((run % 128) != 64) @(negedge clk_i);
    req_i = '0;
    cycles(5);
    tag = "R4";
    req_i = 4'b0110;
    for (int i = 0; i < 140; i++) begin
      sel_i = 3'(i % 8);
      cycles(37);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule